// File: doc/BRIEF.md
# Multicore Attention Strobe Fabric

This block is a doorbell network for an array of processor cores. Each core can raise an attention request that carries a target mask with one bit per core. When the fabric accepts the request, it sends a strobe to every core the mask names, excluding the sender itself. The strobe lasts one clock, and all targets see it in the same cycle. No payload travels with it. A receiver only learns that some core wanted its attention.

Each receiving core has a dedicated sticky attention flag that captures incoming strobes. This flag is separate from any general edge detectors the core may have. It stays set until the core pulses its consume input.

Several senders may target the same receiver in the same cycle. Their strobes are ORed together with no arbitration and no queueing.

The request side is a valid/ready handshake per core, and acceptance occupies the sender for two clocks. If a core holds `req_valid` high, the fabric back-pressures it by dropping `req_ready` for the cycle that follows each acceptance. The mask must stay stable while valid is high and ready is low. Strobe, consume and flag pins are plain control signals without a handshake.

Top module: `atn_fabric`

## Requirements
- R1: A request from core s is accepted on a rising edge where `req_valid[s]` and `req_ready[s]` are both high. The mask is sampled at that edge from `req_mask[s*16 +: 16]`, where bit t targets core t.
- R2: After an acceptance, `req_ready[s]` is low for exactly one cycle and then returns high. A request held valid continuously is therefore accepted every other cycle.
- R3: `attn_strobe[t]` is high for exactly one cycle, namely the cycle after the accepting edge, for every core t that the accepted mask targets.
- R4: The sender's own mask bit is ignored, so a request never strobes or flags the sending core.
- R5: A single request can strobe any number of target cores in the same cycle, up to all cores other than the sender.
- R6: Strobes from several senders accepted on the same edge are ORed per receiver.
- R7: `attn_flag[t]` becomes set on the edge at which `attn_strobe[t]` is high. It then holds until `attn_clr[t]` is high at an edge while no strobe is arriving.
- R8: If `attn_strobe[t]` and `attn_clr[t]` are high on the same edge, `attn_flag[t]` stays set.
- R9: A synchronous active-low reset clears all flags and strobes and leaves every `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 16 | Per-core attention request valid |
| req_ready | output | 16 | Per-core request ready (low while the sender is occupied) |
| req_mask | input | 256 | Per-core target masks; core s uses bits [s*16 +: 16] |
| attn_strobe | output | 16 | One-cycle attention strobe per receiving core |
| attn_clr | input | 16 | Per-core consume/clear of the attention flag |
| attn_flag | output | 16 | Per-core sticky attention flag |

## Verification
A corrupted pending-mask register shows on `attn_strobe` in the very next cycle, either as a wrong target or as a pulse longer than one clock. From there it reaches `attn_flag` one edge later, where the sticky flag keeps the error visible until it is cleared. A wrong occupancy state shows on `req_ready` in the cycle right after acceptance. A fault in the flag's priority between set and clear shows only when a strobe and a consume meet on the same edge. For that reason the collision case is driven on purpose.

// File: rtl/atn_pkg.sv
package atn_pkg;
  parameter int unsigned ATN_CORES = 16;

  // Drop one core's own bit from a target mask.
  function automatic logic [ATN_CORES-1:0] drop_self(
    input logic [ATN_CORES-1:0] mask,
    input int unsigned          self_idx
  );
    logic [ATN_CORES-1:0] m;
    m = mask;
    m[self_idx] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/atn_sender.sv
module atn_sender #(
  parameter int unsigned N    = 16,
  parameter int unsigned SELF = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  output logic         ready,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend
);
  logic busy_q;
  logic fire;
  logic [N-1:0] m;

  assign ready = !busy_q;
  assign fire  = valid && ready;

  always_comb begin
    m = mask;
    m[SELF] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend   <= '0;
    end else begin
      busy_q <= fire;
      pend   <= fire ? m : '0;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !ready); // R2
  AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready); // R2
  AST_PEND_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0) |=> (pend == '0)); // R3
  AST_NO_SELF_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pend[SELF]); // R4
endmodule

// File: rtl/atn_merge.sv
module atn_merge #(
  parameter int unsigned N = 16
) (
  input  logic [N*N-1:0] pend_flat,
  output logic [N-1:0]   strobe
);
  genvar t;
  generate
    for (t = 0; t < N; t++) begin : g_rx
      logic [N-1:0] col;
      genvar s;
      for (s = 0; s < N; s++) begin : g_tx
        assign col[s] = pend_flat[s*N + t];
      end
      assign strobe[t] = |col;
    end
  endgenerate
endmodule

// File: rtl/atn_flag_bank.sv
module atn_flag_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] flag
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)         flag[i] <= 1'b0;
        else if (set_in[i]) flag[i] <= 1'b1;
        else if (clr_in[i]) flag[i] <= 1'b0;
      end

      AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_in[i] |=> flag[i]); // R7
      AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[i] && !clr_in[i]) |=> flag[i]); // R7
      AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in[i] && !set_in[i]) |=> !flag[i]); // R7
      AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_in[i] && set_in[i]) |=> flag[i]); // R8
    end
  endgenerate
endmodule

// File: rtl/atn_fabric.sv
module atn_fabric
  import atn_pkg::*;
#(
  parameter int unsigned N = ATN_CORES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_valid,
  output logic [N-1:0]   req_ready,
  input  logic [N*N-1:0] req_mask,
  output logic [N-1:0]   attn_strobe,
  input  logic [N-1:0]   attn_clr,
  output logic [N-1:0]   attn_flag
);
  localparam int unsigned MW = N * N;

  logic [MW-1:0] pend_flat;

  genvar s;
  generate
    for (s = 0; s < N; s++) begin : g_tx
      atn_sender #(.N(N), .SELF(s)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (req_valid[s]),
        .ready (req_ready[s]),
        .mask  (req_mask[s*N +: N]),
        .pend  (pend_flat[s*N +: N])
      );
    end
  endgenerate

  atn_merge #(.N(N)) u_merge (
    .pend_flat (pend_flat),
    .strobe    (attn_strobe)
  );

  atn_flag_bank #(.N(N)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_in (attn_strobe),
    .clr_in (attn_clr),
    .flag   (attn_flag)
  );

  AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_strobe != '0) |-> ($past(req_valid & req_ready) != '0)); // R3
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(attn_flag) | $past(attn_strobe)) | ~attn_flag) == '1); // R7
endmodule

// File: tb/atn_fabric_bench.sv
module atn_fabric_bench;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   req_valid = '0;
  logic [N-1:0]   req_ready;
  logic [N*N-1:0] req_mask = '0;
  logic [N-1:0]   attn_strobe;
  logic [N-1:0]   attn_clr = '0;
  logic [N-1:0]   attn_flag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  atn_fabric #(.N(N)) u_atn_fabric (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .attn_strobe(attn_strobe), .attn_clr(attn_clr),
    .attn_flag(attn_flag)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    attn_clr = '1;
    @(posedge clk); @(negedge clk);
    attn_clr = '0;
    chk("R7 clear", attn_flag, '0);
  endtask

  // single sender s with mask m; all checks computed from requirements
  task automatic send_one(input int s, input logic [N-1:0] m);
    logic [N-1:0] exp;
    exp = m & ~(16'(1) << s);
    req_valid[s] = 1'b1;
    req_mask[s*N +: N] = m;
    @(posedge clk); @(negedge clk);
    req_valid[s] = 1'b0;
    chk("R2 busy", req_ready, ~(16'(1) << s));
    chk("R3/R4/R5 strobe", attn_strobe, exp);
    @(posedge clk); @(negedge clk);
    chk("R3 strobe width", attn_strobe, '0);
    chk("R2 ready back", req_ready, '1);
    chk("R7 flag", attn_flag, exp);
  endtask

  initial begin
    logic [N-1:0] acc;
    logic [N-1:0] pat;
    int pulses;
    repeat (3) @(negedge clk);
    chk("R9 reset flag", attn_flag, '0);
    chk("R9 reset strobe", attn_strobe, '0);
    chk("R9 reset ready", req_ready, '1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R4: every sender to every single target
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        send_one(s, 16'(1) << t);
        clear_all();
      end
    end

    // R5: broadcast and arithmetic patterns per sender
    for (int s = 0; s < N; s++) begin
      send_one(s, '1);
      clear_all();
      pat = 16'((s * 40503 + 7) ^ (s << 9));
      send_one(s, pat);
      clear_all();
    end

    // R6: all senders at once, each targets its successor; also pairs on one target
    for (int s = 0; s < N; s++) begin
      req_valid[s] = 1'b1;
      req_mask[s*N +: N] = 16'(1) << ((s + 1) % N);
    end
    @(posedge clk); @(negedge clk);
    req_valid = '0;
    chk("R6 all senders OR", attn_strobe, '1);
    chk("R2 all busy", req_ready, '0);
    @(posedge clk); @(negedge clk);
    chk("R6 flags", attn_flag, '1);
    clear_all();
    for (int a = 0; a < N; a++) begin
      int b;
      b = (a + 5) % N;
      req_valid[a] = 1'b1; req_mask[a*N +: N] = 16'h0001 << 3 | (16'(1) << b);
      req_valid[b] = 1'b1; req_mask[b*N +: N] = 16'h0001 << 3 | (16'(1) << a);
      acc = ((16'h0008 | (16'(1) << b)) & ~(16'(1) << a)) |
            ((16'h0008 | (16'(1) << a)) & ~(16'(1) << b));
      @(posedge clk); @(negedge clk);
      req_valid = '0;
      chk("R6 pair merge", attn_strobe, acc);
      @(posedge clk); @(negedge clk);
      chk("R6 pair flags", attn_flag, acc);
      clear_all();
    end

    // R2: held-valid back-pressure yields every other cycle
    req_valid[2] = 1'b1;
    req_mask[2*N +: N] = 16'h0100;
    pulses = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (attn_strobe[8]) pulses++;
    end
    req_valid[2] = 1'b0;
    checks++;
    if (pulses != 4) begin
      errors++;
      $display("FAIL R2 held valid pulses actual=%0d expected=4", pulses);
    end
    @(posedge clk); @(negedge clk);
    clear_all();

    // R7 hold and R8 set-over-clear
    for (int t = 0; t < N; t++) begin
      int s;
      s = (t + 1) % N;
      req_valid[s] = 1'b1;
      req_mask[s*N +: N] = 16'(1) << t;
      @(posedge clk); @(negedge clk);
      req_valid[s] = 1'b0;
      attn_clr[t] = 1'b1;          // collides with strobe on next edge
      @(posedge clk); @(negedge clk);
      attn_clr[t] = 1'b0;
      chk("R8 set wins", attn_flag, 16'(1) << t);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R7 hold", attn_flag, 16'(1) << t);
      attn_clr[t] = 1'b1;
      @(posedge clk); @(negedge clk);
      attn_clr[t] = 1'b0;
      chk("R7 consume", attn_flag, '0);
    end

    // R9: reset mid-operation clears flags
    send_one(4, 16'h00F0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 reset clears", attn_flag, '0);
    rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule